// File: doc/BRIEF.md
# Prioritised multifunction shift register

This block is a parallel register, WIDTH bits wide (four by default), whose next value is picked from four sources: its own contents (hold), a parallel data word (load), its contents moved one place toward the least significant bit (shift right), or its contents moved one place toward the most significant bit (shift left). Each shift direction has its own serial input. A shift right feeds its serial input into the MSB. A shift left feeds its serial input into the LSB.

The caller drives three independent request lines, and any mix of them may be high together. A small combinational priority encoder reduces the requests to a 2-bit mode select. That select steers a 4-to-1 multiplexer in front of every flip-flop. Load wins over both shift requests. Shift right wins over shift left. With no request high, the register keeps its contents. The register contents are available in parallel at all times.

Top module: `prio_shift_reg`

## Requirements
- R1: While rst_ni is low, q_o is all zeros, independent of the clock and of every request; reset takes effect without waiting for a clock edge.
- R2: On a rising clock edge with load_i high, q_o takes the value of data_i, whatever shr_i and shl_i are.
- R3: On a rising clock edge with load_i low and shr_i high, the register shifts right even when shl_i is also high.
- R4: A right shift moves bit i+1 into bit i for every bit below the MSB, and puts shr_in_i into the MSB.
- R5: On a rising clock edge with load_i and shr_i low and shl_i high, bit i-1 moves into bit i for every bit above the LSB, and shl_in_i goes into the LSB.
- R6: On a rising clock edge with no request high, q_o keeps its value; data_i and the serial inputs have no effect.
- R7: The internal mode select uses 00 for hold, 01 for load, 10 for shift right and 11 for shift left, and is decided only by the three requests.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Parallel load request (highest priority) |
| shr_i | input | 1 | Shift right request |
| shl_i | input | 1 | Shift left request (lowest priority) |
| data_i | input | WIDTH | Parallel load data |
| shr_in_i | input | 1 | Serial input entering the MSB on a right shift |
| shl_in_i | input | 1 | Serial input entering the LSB on a left shift |
| q_o | output | WIDTH | Register contents |

## Verification
On every cycle the assertions check the register update for all four modes. This covers the load value, both shift patterns with their serial fill bits, and hold stability. They also check that the mode select matches the priority order for the current requests and that reset clears the register. Some behaviours only the bench scenarios can show. One is that overlapping requests resolve correctly across long runs of chained operations, compared against an independent model for all eight request combinations. Another is that an asynchronous reset between clock edges clears the contents at once and holds them through later edges while requests are present.

// File: rtl/psr_pkg.sv
package psr_pkg;

  typedef enum logic [1:0] {
    MODE_HOLD  = 2'b00,
    MODE_LOAD  = 2'b01,
    MODE_SHR   = 2'b10,
    MODE_SHL   = 2'b11
  } psr_mode_e;

endpackage

// File: rtl/psr_req_encoder.sv
module psr_req_encoder
  import psr_pkg::*;
(
  input  logic      load_i,
  input  logic      shr_i,
  input  logic      shl_i,
  output psr_mode_e mode_o
);

  logic sel_hi, sel_lo;

  // Fixed priority equations: load > shift right > shift left > hold
  assign sel_hi = ~load_i & (shr_i | shl_i);
  assign sel_lo = load_i | (~shr_i & shl_i);

  assign mode_o = psr_mode_e'({sel_hi, sel_lo});

endmodule

// File: rtl/psr_bit_mux.sv
module psr_bit_mux
  import psr_pkg::*;
(
  input  psr_mode_e mode_i,
  input  logic      own_i,
  input  logic      par_i,
  input  logic      upper_i,
  input  logic      lower_i,
  output logic      next_o
);

  always_comb begin
    unique case (mode_i)
      MODE_HOLD: next_o = own_i;
      MODE_LOAD: next_o = par_i;
      MODE_SHR:  next_o = upper_i;
      MODE_SHL:  next_o = lower_i;
      default:   next_o = own_i;
    endcase
  end

endmodule

// File: rtl/psr_store.sv
module psr_store #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d_i;
  end

endmodule

// File: rtl/prio_shift_reg.sv
module prio_shift_reg
  import psr_pkg::*;
#(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             shr_i,
  input  logic             shl_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             shr_in_i,
  input  logic             shl_in_i,
  output logic [WIDTH-1:0] q_o
);

  localparam int unsigned MsbIdx = WIDTH - 1;

  psr_mode_e        mode;
  logic [WIDTH-1:0] q_next;

  psr_req_encoder u_enc (
    .load_i (load_i),
    .shr_i  (shr_i),
    .shl_i  (shl_i),
    .mode_o (mode)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic upper_w, lower_w;

    if (i == MsbIdx) begin : g_top
      assign upper_w = shr_in_i;
    end else begin : g_mid_hi
      assign upper_w = q_o[i+1];
    end

    if (i == 0) begin : g_bot
      assign lower_w = shl_in_i;
    end else begin : g_mid_lo
      assign lower_w = q_o[i-1];
    end

    psr_bit_mux u_mux (
      .mode_i  (mode),
      .own_i   (q_o[i]),
      .par_i   (data_i[i]),
      .upper_i (upper_w),
      .lower_i (lower_w),
      .next_o  (q_next[i])
    );
  end

  psr_store #(.WIDTH(WIDTH)) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (q_next),
    .q_o    (q_o)
  );

endmodule

// File: rtl/psr_checker.sv
module psr_checker
  import psr_pkg::*;
#(
  parameter int unsigned WIDTH = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             load_i,
  input logic             shr_i,
  input logic             shl_i,
  input logic [WIDTH-1:0] data_i,
  input logic             shr_in_i,
  input logic             shl_in_i,
  input logic [WIDTH-1:0] q_o,
  input psr_mode_e        mode
);

  logic [WIDTH:0] shr_cat, shl_cat;
  assign shr_cat = {shr_in_i, q_o};
  assign shl_cat = {q_o, shl_in_i};

  AST_RESET_CLEARS: assert property (@(posedge clk_i)
    !rst_ni |-> q_o == '0) else $error("reset"); // R1

  AST_LOAD_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> q_o == $past(data_i)) else $error("load"); // R2

  AST_SHR_OVER_SHL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && shr_i) |=> q_o == $past(shr_cat[WIDTH:1])) else $error("shr"); // R3

  AST_SHL_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !shr_i && shl_i) |=> q_o == $past(shl_cat[WIDTH-1:0])) else $error("shl"); // R5

  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !shr_i && !shl_i) |=> $stable(q_o)) else $error("hold"); // R6

  AST_MODE_PRIO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shr_i && shl_i && !load_i) |-> mode == MODE_SHR) else $error("mode"); // R7

endmodule

bind prio_shift_reg psr_checker #(.WIDTH(WIDTH)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .load_i   (load_i),
  .shr_i    (shr_i),
  .shl_i    (shl_i),
  .data_i   (data_i),
  .shr_in_i (shr_in_i),
  .shl_in_i (shl_in_i),
  .q_o      (q_o),
  .mode     (mode)
);

// File: tb/prio_shift_reg_tb.sv
module prio_shift_reg_tb;

  localparam int unsigned W = 4;
  localparam int unsigned NVEC = 8;
  // {load, shr, shl, shr_in, shl_in, data[3:0], expected[3:0]}
  localparam logic [12:0] VEC [NVEC] = '{
    {5'b11100, 4'b1011, 4'b1011},  // R2 load over both shifts
    {5'b00011, 4'b0000, 4'b1011},  // R6 hold
    {5'b01110, 4'b0000, 4'b1101},  // R3 shr over shl, fill 1
    {5'b01000, 4'b1111, 4'b0110},  // R4 fill 0
    {5'b00101, 4'b0000, 4'b1101},  // R5 fill 1
    {5'b00100, 4'b1111, 4'b1010},  // R5 fill 0
    {5'b10111, 4'b0110, 4'b0110},  // R2 load over shl
    {5'b00011, 4'b1111, 4'b0110}   // R6 data ignored
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic load, shr, shl, sri, sli;
  logic [W-1:0] din, q;
  int n_chk = 0, n_fail = 0;
  logic [W-1:0] model;

  always #5 clk = ~clk;

  prio_shift_reg #(.WIDTH(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .load_i(load), .shr_i(shr), .shl_i(shl),
    .data_i(din), .shr_in_i(sri), .shl_in_i(sli), .q_o(q)
  );

  task automatic check(input string req, input logic [W-1:0] exp);
    n_chk++;
    if (q !== exp) begin
      n_fail++;
      $display("FAIL %s: q=%b expected %b", req, q, exp);
    end
  endtask

  task automatic step(input logic l, input logic r, input logic s,
                      input logic a, input logic b, input logic [W-1:0] d);
    @(negedge clk);
    load = l; shr = r; shl = s; sri = a; sli = b; din = d;
    @(posedge clk);
    #1;
  endtask

  function automatic logic [W-1:0] ref_next(input logic [W-1:0] cur,
      input logic l, input logic r, input logic s,
      input logic a, input logic b, input logic [W-1:0] d);
    if (l) return d;
    if (r) return {a, cur[W-1:1]};
    if (s) return {cur[W-2:0], b};
    return cur;
  endfunction

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: q=%b expected completion", q);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    load = 0; shr = 0; shl = 0; sri = 0; sli = 0; din = '0;
    #1 check("R1", '0);
    @(negedge clk); @(negedge clk);
    check("R1", '0);
    rst_ni = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][12], VEC[i][11], VEC[i][10], VEC[i][9], VEC[i][8], VEC[i][7:4]);
      check(VEC[i][12] ? "R2" : VEC[i][11] ? "R3/R4" : VEC[i][10] ? "R5" : "R6",
            VEC[i][3:0]);
    end

    model = q;
    for (int k = 0; k < 128; k++) begin
      logic [2:0] c;
      logic a, b;
      logic [W-1:0] d;
      c = 3'(k % 8);
      a = 1'($urandom);
      b = 1'($urandom);
      d = W'($urandom);
      model = ref_next(model, c[2], c[1], c[0], a, b, d);
      step(c[2], c[1], c[0], a, b, d);
      check(c[2] ? "R2" : c[1] ? "R3" : c[0] ? "R5" : "R6", model);
    end

    // R4 all-ones fill walks in from MSB
    step(1, 0, 0, 0, 0, '0);
    for (int j = 0; j < W; j++) step(0, 1, 0, 1, 0, '0);
    check("R4", '1);
    // R5 zero fill walks in from LSB
    for (int j = 0; j < W; j++) step(0, 0, 1, 0, 0, '1);
    check("R5", '0);

    // R1 asynchronous clear between edges, held across edges with requests
    step(1, 0, 0, 0, 0, 4'b1001);
    check("R2", 4'b1001);
    @(negedge clk);
    #2 rst_ni = 1'b0;
    #1 check("R1", '0);
    load = 1; din = 4'b1111;
    @(posedge clk); #1 check("R1", '0);
    @(negedge clk); rst_ni = 1'b1; load = 0;
    step(0, 0, 0, 1, 1, '1);
    check("R6", '0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule